// File: doc/BRIEF.md
# Parallel NOR Flash Erase/Program Sequencer

This block is a bus master that carries out a complete erase or program job on an asynchronous parallel NOR flash through the flash's command interface. A client hands it one request: an operation (erase one block, or program a run of consecutive words), a start word address and, for programming, a word count. While a program job runs, the block presents the index of the word it is about to write on `wdata_idx`. The client answers combinationally with that word's data on `wdata`.

For each job the block writes the command codes and polls the device status word until the ready bit appears. A poll budget guards against a device that never becomes ready. After that the block turns the error bits into one result code and puts the device back into read-array mode. It then checks the outcome by reading the flash back. After an erase every word of the block must read as all ones. After a program each word must read back as the value written. The result is reported with a one-cycle done pulse.

The flash side is a synchronous strobe interface. Every access is a one-cycle strobe that carries the direction, address and write data. Read data is sampled a fixed number of cycles after the strobe. Command writes that target the device rather than a word use word address 0.

Top module: `nor_flash_seq`

## Requirements
- R1: While reset is held and in the cycle after it, `busy`, `done` and `fl_stb` are low and `result` reads 0 (OK).
- R2: A request (`req_valid` high for one cycle) is taken only while `busy` is low. A request presented while a job is running has no effect on the flash contents, on the number of done pulses or on the running job's result.
- R3: An erase writes 0x50 to address 0, then 0x20 to address 0, then 0xD0 to the request address itself (`req_op`=0 selects erase). Every flash access is a strobe exactly one cycle long.
- R4: Programming (`req_op`=1) writes 0x50 to address 0 once. Then, for word i, it writes 0x40 to address 0 and the data to `req_addr`+i, and that data is the `wdata` value present while `wdata_idx` equals i. After a clean status it writes 0x50 and then 0xFF to address 0 and reads the word back.
- R5: Status is read from address 0 until bit 7 (0x80) is set. After POLL_LIMIT reads without that bit, the job ends with result 1 (TIMEOUT) and no read-back check is done.
- R6: A ready status whose bits under mask 0x7E are all clear gives 0 (OK). Otherwise the result is chosen by the first match in this list: the operation's own bit is clear (0x20 for erase, 0x10 for program) gives 2 (HW_ERR); 0x08 set gives 3 (LOW_VOLTAGE); 0x02 set gives 4 (PROTECT); anything else gives 5 (ERASE_FAIL) or 6 (PROGRAM_FAIL).
- R7: On every exit path, the last flash write before `done` is 0xFF to address 0.
- R8: After an erase that did not time out, the words of the BLOCK_WORDS-aligned block that holds the request address are read in ascending order. The first word that is not all ones stops the check. It sets result 7 (VERIFY_FAIL) only when no error was recorded before.
- R9: A program job stops at the first word whose status shows an error, or whose read-back differs from the written data (result 7). The words after it are not written.
- R10: `busy` is high from the cycle after acceptance through the cycle in which `done` is high. `done` is high for exactly one cycle, and `busy` falls right after it.
- R11: A program request of length 0 writes only 0x50 and then 0xFF to address 0, and ends with result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 1 | 0 = erase block, 1 = program words |
| req_addr | input | AW | Start word address (erase: any word inside the block) |
| req_len | input | LW | Number of words to program |
| wdata_idx | output | LW | Index of the word whose data is wanted |
| wdata | input | DW | Data for word `wdata_idx` |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| result | output | 3 | Result code, valid with `done` |
| fl_stb | output | 1 | Flash access strobe |
| fl_we | output | 1 | Flash access is a write |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |

## Verification
The assertions assume that the flash returns read data within ACC_LAT cycles of the strobe. They also assume that `req_valid` lasts a single cycle when it starts a job, because acceptance is judged by the rise of `busy` one cycle after the request. The bench's flash model latches read data at the strobe edge. This keeps the latency at two cycles, and the bench drives every request for exactly one cycle. A spurious request sent in the middle of a job is kept to one cycle, so it cannot overlap the job's end.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_TIMEOUT  = 3'd1,
        RES_HW_ERR   = 3'd2,
        RES_LOW_VOLT = 3'd3,
        RES_PROTECT  = 3'd4,
        RES_ERASE    = 3'd5,
        RES_PROGRAM  = 3'd6,
        RES_VERIFY   = 3'd7
    } nfs_result_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR,
        S_CMD,
        S_ARG,
        S_POLL,
        S_FIN,
        S_CLR2,
        S_RST2,
        S_RDBK,
        S_VFY,
        S_DONE
    } nfs_state_e;

    // command codes written to the device
    localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

    // status word bits
    localparam logic [7:0] ST_READY    = 8'h80;
    localparam logic [7:0] ST_ERR_MASK = 8'h7E;
    localparam logic [7:0] ST_ERASE    = 8'h20;
    localparam logic [7:0] ST_PROG     = 8'h10;
    localparam logic [7:0] ST_LOW_VOLT = 8'h08;
    localparam logic [7:0] ST_LOCKED   = 8'h02;

    typedef struct packed {
        logic        ready;
        logic        failed;
        nfs_result_e code;
    } nfs_status_t;

    function automatic nfs_result_e classify(logic [7:0] st, logic is_prog);
        nfs_result_e r;
        if ((st & ST_ERR_MASK) == 8'h00)
            r = RES_OK;
        else if ((st & (is_prog ? ST_PROG : ST_ERASE)) == 8'h00)
            r = RES_HW_ERR;
        else if ((st & ST_LOW_VOLT) != 8'h00)
            r = RES_LOW_VOLT;
        else if ((st & ST_LOCKED) != 8'h00)
            r = RES_PROTECT;
        else
            r = is_prog ? RES_PROGRAM : RES_ERASE;
        return r;
    endfunction

endpackage

// File: rtl/nfs_bus_port.sv
module nfs_bus_port #(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int ACC_LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          fl_stb,
    output logic          fl_we,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata
);
    localparam int CW = $clog2(ACC_LAT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ack      <= 1'b0;
            rdata    <= '0;
            fl_stb   <= 1'b0;
            fl_we    <= 1'b0;
            fl_addr  <= '0;
            fl_wdata <= '0;
        end else begin
            ack    <= 1'b0;
            fl_stb <= 1'b0;
            if (go) begin
                fl_stb   <= 1'b1;
                fl_we    <= we;
                fl_addr  <= addr;
                fl_wdata <= wdata;
                cnt      <= CW'(ACC_LAT);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    ack   <= 1'b1;
                    rdata <= fl_rdata;
                end
            end
        end
    end
endmodule

// File: rtl/nfs_status_decode.sv
module nfs_status_decode
    import nfs_pkg::*;
(
    input  logic [7:0]  status,
    input  logic        is_prog,
    output nfs_status_t info
);
    always_comb begin
        info.ready  = (status & ST_READY) != 8'h00;
        info.code   = classify(status, is_prog);
        info.failed = info.code != RES_OK;
    end
endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
    import nfs_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int LW          = 8,
    parameter int BLOCK_WORDS = 64,
    parameter int POLL_LIMIT  = 5000000,
    parameter int ACC_LAT     = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic [LW-1:0] wdata_idx,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic [2:0]    result,
    output logic          fl_stb,
    output logic          fl_we,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata
);
    localparam int BLK_BITS = $clog2(BLOCK_WORDS);
    localparam int IDXW     = (LW > BLK_BITS) ? LW : BLK_BITS;
    localparam int PCW      = $clog2(POLL_LIMIT + 1);
    localparam logic [AW-1:0] BLK_MASK = ~AW'(BLOCK_WORDS - 1);
    localparam logic [DW-1:0] BLANK    = '1;

    function automatic logic [DW-1:0] cw(logic [7:0] c);
        return DW'(c);
    endfunction

    nfs_state_e    state;
    logic          issued;
    logic          op_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] len_q;
    logic [IDXW-1:0] idx;
    logic [PCW-1:0]  poll_cnt;
    nfs_result_e   res_q;
    logic [DW-1:0] wd_q;

    logic          bus_go, bus_need, bus_we, ack;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wd, rdata;
    nfs_status_t   st_info;

    logic [AW-1:0] word_addr, vfy_addr;
    logic          last_prog, last_vfy;

    assign word_addr = addr_q + AW'(idx);
    assign vfy_addr  = (addr_q & BLK_MASK) + AW'(idx);
    assign last_prog = ({1'b0, idx} + 1'b1) == (IDXW + 1)'(len_q);
    assign last_vfy  = idx == IDXW'(BLOCK_WORDS - 1);

    nfs_bus_port #(.AW(AW), .DW(DW), .ACC_LAT(ACC_LAT)) u_port (
        .clk      (clk),
        .rst      (rst),
        .go       (bus_go),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wd),
        .ack      (ack),
        .rdata    (rdata),
        .fl_stb   (fl_stb),
        .fl_we    (fl_we),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .fl_rdata (fl_rdata)
    );

    nfs_status_decode u_dec (
        .status  (rdata[7:0]),
        .is_prog (op_q),
        .info    (st_info)
    );

    // access requested by the current state
    always_comb begin
        bus_need = 1'b1;
        bus_we   = 1'b0;
        bus_addr = '0;
        bus_wd   = '0;
        unique case (state)
            S_CLR, S_CLR2: begin
                bus_we = 1'b1;
                bus_wd = cw(CMD_CLR_STATUS);
            end
            S_CMD: begin
                bus_we = 1'b1;
                bus_wd = op_q ? cw(CMD_PROG_SETUP) : cw(CMD_ERASE_SETUP);
            end
            S_ARG: begin
                bus_we   = 1'b1;
                bus_addr = op_q ? word_addr : addr_q;
                bus_wd   = op_q ? wdata : cw(CMD_CONFIRM);
            end
            S_POLL: bus_we = 1'b0;
            S_FIN, S_RST2: begin
                bus_we = 1'b1;
                bus_wd = cw(CMD_READ_ARRAY);
            end
            S_RDBK: bus_addr = word_addr;
            S_VFY:  bus_addr = vfy_addr;
            default: bus_need = 1'b0;
        endcase
        bus_go = bus_need && !issued;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            issued   <= 1'b0;
            op_q     <= 1'b0;
            addr_q   <= '0;
            len_q    <= '0;
            idx      <= '0;
            poll_cnt <= '0;
            res_q    <= RES_OK;
            wd_q     <= '0;
        end else begin
            if (bus_go) issued <= 1'b1;
            if (bus_go && state == S_ARG) wd_q <= wdata;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    addr_q <= req_addr;
                    len_q  <= req_len;
                    idx    <= '0;
                    res_q  <= RES_OK;
                    state  <= S_CLR;
                end
                S_CLR: if (ack) begin
                    issued <= 1'b0;
                    state  <= (op_q && len_q == '0) ? S_FIN : S_CMD;
                end
                S_CMD: if (ack) begin
                    issued <= 1'b0;
                    state  <= S_ARG;
                end
                S_ARG: if (ack) begin
                    issued   <= 1'b0;
                    poll_cnt <= '0;
                    state    <= S_POLL;
                end
                S_POLL: if (ack) begin
                    issued <= 1'b0;
                    if (st_info.ready) begin
                        res_q <= st_info.code;
                        state <= (op_q && !st_info.failed) ? S_CLR2 : S_FIN;
                    end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                        res_q <= RES_TIMEOUT;
                        state <= S_FIN;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                S_FIN: if (ack) begin
                    issued <= 1'b0;
                    idx    <= '0;
                    state  <= (!op_q && res_q != RES_TIMEOUT) ? S_VFY : S_DONE;
                end
                S_CLR2: if (ack) begin
                    issued <= 1'b0;
                    state  <= S_RST2;
                end
                S_RST2: if (ack) begin
                    issued <= 1'b0;
                    state  <= S_RDBK;
                end
                S_RDBK: if (ack) begin
                    issued <= 1'b0;
                    if (rdata != wd_q) begin
                        res_q <= RES_VERIFY;
                        state <= S_DONE;
                    end else if (last_prog) begin
                        state <= S_FIN;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_CMD;
                    end
                end
                S_VFY: if (ack) begin
                    issued <= 1'b0;
                    if (rdata != BLANK) begin
                        if (res_q == RES_OK) res_q <= RES_VERIFY;
                        state <= S_DONE;
                    end else if (last_vfy) begin
                        state <= S_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = state != S_IDLE;
    assign done      = state == S_DONE;
    assign result    = res_q;
    assign wdata_idx = LW'(idx);

endmodule

// File: rtl/nfs_chk.sv
module nfs_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic          fl_stb,
    input logic          fl_we,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_wdata
);
    logic          seen_w;
    logic [AW-1:0] last_a;
    logic [DW-1:0] last_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_w <= 1'b0;
            last_a <= '0;
            last_w <= '0;
        end else if (fl_stb && fl_we) begin
            seen_w <= 1'b1;
            last_a <= fl_addr;
            last_w <= fl_wdata;
        end
    end

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    // R2
    accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    // R7
    read_mode_exit_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> seen_w && last_a == '0 && last_w == DW'(8'hFF));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !fl_stb);

    // R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fl_stb |=> !fl_stb);

endmodule

bind nor_flash_seq nfs_chk #(.AW(AW), .DW(DW)) u_nfs_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .fl_stb   (fl_stb),
    .fl_we    (fl_we),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata)
);

// File: tb/tb_nor_flash_seq.sv
module tb_nor_flash_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int LW = 6;
    localparam int BLK = 16;
    localparam int PLIM = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_op = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [LW-1:0] wdata_idx;
    logic [DW-1:0] wdata;
    logic busy, done;
    logic [2:0] result;
    logic fl_stb, fl_we;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [DW-1:0] fl_rdata = '0;
    logic [15:0] seed = 16'h5A00;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign wdata = (16'(wdata_idx) * 16'h0101) ^ seed;

    nor_flash_seq #(.AW(AW), .DW(DW), .LW(LW), .BLOCK_WORDS(BLK),
                    .POLL_LIMIT(PLIM), .ACC_LAT(2)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .wdata_idx(wdata_idx),
        .wdata(wdata), .busy(busy), .done(done), .result(result),
        .fl_stb(fl_stb), .fl_we(fl_we), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    // ---------------- flash model ----------------
    logic [15:0] mem [0:255];
    int  pend = 0;          // 0 none, 1 erase setup, 2 program setup
    bit  st_mode = 0;
    int  busy_polls = 0;
    int  poll_seen = 0;
    int  err_inj = 0;
    bit  stuck_en = 0;
    int  stuck_a = 0;
    int  wcount = 0;
    int  poll_reads = 0;
    int  done_cnt = 0;
    int  wlog_a [0:63];
    int  wlog_d [0:63];

    always @(posedge clk) begin
        if (done) done_cnt++;
        if (fl_stb && fl_we) begin
            if (wcount < 64) begin
                wlog_a[wcount] = int'(fl_addr);
                wlog_d[wcount] = int'(fl_wdata);
            end
            wcount++;
            if (pend == 2) begin
                pend = 0;
                if (!(stuck_en && int'(fl_addr) == stuck_a))
                    mem[fl_addr] = mem[fl_addr] & fl_wdata;
                st_mode = 1; poll_seen = 0;
            end else if (pend == 1) begin
                pend = 0;
                if (fl_wdata == 16'h00D0) begin
                    for (int i = 0; i < BLK; i++) begin
                        int a;
                        a = (int'(fl_addr) & ~(BLK-1)) + i;
                        if (!(stuck_en && a == stuck_a)) mem[a] = 16'hFFFF;
                    end
                    st_mode = 1; poll_seen = 0;
                end
            end else begin
                case (fl_wdata)
                    16'h00FF: st_mode = 0;
                    16'h0020: pend = 1;
                    16'h0040: pend = 2;
                    default: ;
                endcase
            end
        end else if (fl_stb) begin
            if (st_mode) begin
                poll_reads++;
                if (poll_seen < busy_polls) begin
                    poll_seen++;
                    fl_rdata <= 16'h0000;
                end else begin
                    fl_rdata <= 16'(8'h80 | err_inj);
                end
            end else begin
                fl_rdata <= mem[fl_addr];
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(int st, bit prog);
        if ((st & 'h7E) == 0) return 0;
        if ((st & (prog ? 'h10 : 'h20)) == 0) return 2;
        if ((st & 'h08) != 0) return 3;
        if ((st & 'h02) != 0) return 4;
        return prog ? 6 : 5;
    endfunction

    function automatic int dat(int i);
        return int'((16'(i) * 16'h0101) ^ seed);
    endfunction

    task automatic fill(input bit erased);
        for (int i = 0; i < 256; i++) mem[i] = erased ? 16'hFFFF : 16'(i*3 + 1);
    endtask

    // runs one job, returns result and handshake flag
    task automatic run_op(input bit op, input int addr, input int len,
                          input bit spurious, output int res, output bit hs);
        int cyc;
        wcount = 0; poll_reads = 0; done_cnt = 0; pend = 0;
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = AW'(addr); req_len = LW'(len);
        @(negedge clk);
        req_valid = 0;
        hs = busy;
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (!busy) hs = 0;
            if (spurious && cyc == 6) begin
                req_valid = 1; req_op = ~op; req_addr = 8'hF0; req_len = 3;
            end
            if (spurious && cyc == 7) req_valid = 0;
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 20000, "R10", "watchdog on done", cyc, 0);
        if (!busy) hs = 0;
        res = int'(result);
        @(negedge clk);
        if (busy || done) hs = 0;
        if (done_cnt != 1) hs = 0;
    endtask

    function automatic bit last_is_reset();
        if (wcount == 0 || wcount > 64) return 0;
        return wlog_a[wcount-1] == 0 && wlog_d[wcount-1] == 'hFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int res;
        bit hs;
        int bad;
        fill(0);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fl_stb, "R1", "idle outputs in reset", {busy, done, fl_stb}, 0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !fl_stb, "R1", "idle outputs after reset", {busy, done, fl_stb}, 0);
        chk(result == 0, "R1", "result after reset", result, 0);

        // erase sweep over every block, offset inside the block varies
        for (int b = 0; b < 256/BLK; b++) begin
            int a;
            fill(0);
            busy_polls = b % 4; err_inj = 0;
            a = b*BLK + (b % BLK);
            run_op(0, a, 0, 0, res, hs);
            chk(res == 0, "R3", "erase result", res, 0);
            chk(hs, "R10", "erase busy/done handshake", hs, 1);
            chk(wcount == 4 && wlog_d[0] == 'h50 && wlog_a[0] == 0 && wlog_d[1] == 'h20
                && wlog_a[1] == 0 && wlog_d[2] == 'hD0 && wlog_a[2] == a,
                "R3", "erase command writes", wcount, 4);
            chk(last_is_reset(), "R7", "erase exit write", wlog_d[3], 'hFF);
            chk(poll_reads == busy_polls + 1, "R5", "erase poll reads", poll_reads, busy_polls + 1);
            bad = 0;
            for (int i = 0; i < 256; i++) begin
                if ((i / BLK) == b) begin
                    if (mem[i] != 16'hFFFF) bad++;
                end else if (mem[i] != 16'(i*3 + 1)) bad++;
            end
            chk(bad == 0, "R8", "erase contents", bad, 0);
        end

        // program sweep over lengths
        busy_polls = 2; err_inj = 0;
        for (int n = 0; n <= 8; n++) begin
            int a;
            fill(1);
            seed = 16'(16'h5A00 + n * 16'h0313);
            a = 16 + n * 10;
            run_op(1, a, n, 0, res, hs);
            chk(res == 0, n == 0 ? "R11" : "R4", "program result", res, 0);
            chk(hs, "R10", "program handshake", hs, 1);
            chk(wcount == 2 + 4*n, n == 0 ? "R11" : "R4", "program write count", wcount, 2 + 4*n);
            chk(last_is_reset(), "R7", "program exit write", wcount, 0);
            bad = 0;
            for (int i = 0; i < n; i++) begin
                int base;
                base = 1 + 4*i;
                if (wlog_d[base] != 'h40 || wlog_a[base] != 0) bad++;
                if (wlog_d[base+1] != dat(i) || wlog_a[base+1] != a + i) bad++;
                if (wlog_d[base+2] != 'h50 || wlog_d[base+3] != 'hFF) bad++;
                if (int'(mem[a+i]) != dat(i)) bad++;
            end
            if (int'(mem[a+n]) != 'hFFFF) bad++;
            chk(bad == 0, "R4", "program words and wdata_idx data", bad, 0);
        end

        // status decode sweep, both operations
        busy_polls = 1;
        for (int k = 0; k < 64; k++) begin
            int e;
            err_inj = k << 1;
            fill(1);
            run_op(1, 100, 2, 0, res, hs);
            e = exp_code(err_inj, 1);
            chk(res == e, "R6", "program status decode", res, e);
            chk(wcount == (e == 0 ? 10 : 4), "R9", "program stops on status error", wcount, e == 0 ? 10 : 4);
            fill(0);
            run_op(0, 37, 0, 0, res, hs);
            e = exp_code(err_inj, 0);
            chk(res == e, "R6", "erase status decode", res, e);
        end
        err_inj = 0;

        // poll limit boundary
        for (int op = 0; op < 2; op++) begin
            fill(1);
            busy_polls = PLIM;
            run_op(op[0], 64, 1, 0, res, hs);
            chk(res == 1, "R5", "timeout result", res, 1);
            chk(poll_reads == PLIM, "R5", "timeout poll reads", poll_reads, PLIM);
            chk(wcount == 4 && last_is_reset(), "R7", "timeout exit writes", wcount, 4);
            busy_polls = PLIM - 1;
            run_op(op[0], 64, 1, 0, res, hs);
            chk(res == 0, "R5", "ready on last poll", res, 0);
            chk(poll_reads == PLIM, "R5", "last-poll reads", poll_reads, PLIM);
        end
        busy_polls = 1;

        // erase verify
        fill(0);
        stuck_en = 1; stuck_a = 3*BLK + 5;
        run_op(0, 3*BLK + 9, 0, 0, res, hs);
        chk(res == 7, "R8", "stuck word in block", res, 7);
        run_op(0, 4*BLK, 0, 0, res, hs);
        chk(res == 0, "R8", "stuck word outside block", res, 0);
        err_inj = 'h28;
        run_op(0, 3*BLK, 0, 0, res, hs);
        chk(res == 3, "R8", "earlier error kept over verify", res, 3);
        err_inj = 0;

        // program verify
        fill(1);
        seed = 16'h1357;
        stuck_a = 200 + 2;
        run_op(1, 200, 5, 0, res, hs);
        chk(res == 7, "R9", "program read-back mismatch", res, 7);
        chk(wcount == 13, "R9", "program stops after mismatch", wcount, 13);
        chk(mem[203] == 16'hFFFF && int'(mem[201]) == dat(1), "R9", "later word untouched", mem[203], 'hFFFF);
        chk(last_is_reset(), "R7", "mismatch exit write", wcount, 13);
        stuck_en = 0;

        // request while busy
        fill(1);
        run_op(0, 2*BLK, 0, 1, res, hs);
        chk(res == 0 && hs, "R2", "job with spurious request", res, 0);
        chk(wcount == 4, "R2", "no extra writes", wcount, 4);
        chk(mem[8'hF0] == 16'hFFFF && mem[8'hF1] == 16'hFFFF, "R2", "spurious target untouched", mem[8'hF0], 'hFFFF);
        repeat (5) @(negedge clk);
        chk(!busy && done_cnt == 1, "R2", "no second job", done_cnt, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule